// File: doc/BRIEF.md
# Serial Command-Vector Transmitter

This block sends one command message down a single asynchronous serial line. A message holds a 6-bit vector index and a 16-bit argument, and always goes out as three characters: the index first, then the low argument byte, then the high argument byte. A one-cycle request strobe starts a message. The index and argument presented with that strobe are captured at once, so the caller may change them on the next cycle.

Each character is framed with a low start bit and eight data bits sent least significant bit first. An optional parity bit follows, then a single high stop bit. The three characters follow each other with no idle time in between. This keeps the line well inside the idle timeout after which a listening receiver drops a partial message. The bit period is the integer quotient of the clock frequency and the bit rate, both given as parameters.

While a message is in flight the block raises busy and ignores further requests. Done pulses for one cycle when the last stop bit ends.

Top module: `vec_cmd_tx`

## Requirements
- R1: Out of reset, and whenever no message is in flight, tx_o is high, busy_o is low and done_o is low.
- R2: A request taken while idle raises busy_o on the next cycle, and tx_o drives the low start bit of the first character in that same cycle.
- R3: Every character begins with one low start bit and ends with one high stop bit.
- R4: Character 0 carries {2'b00, vec_idx_i}, character 1 carries vec_arg_i[7:0] and character 2 carries vec_arg_i[15:8]. Each sends its data bits least significant first, right after its start bit.
- R5: Every bit stays on tx_o for exactly CLK_HZ / BIT_HZ clock cycles (integer division). busy_o therefore stays high for 3 × frame_bits × that many cycles, where frame_bits is 10, or 11 with parity.
- R6: With PARITY_EN = 1, a parity bit sits between the last data bit and the stop bit. It makes the count of ones over data plus parity odd when PARITY_ODD = 1 and even when PARITY_ODD = 0.
- R7: The start bit of characters 1 and 2 follows the preceding stop bit directly, with no idle cycles.
- R8: A request made while busy_o is high has no effect: the message in flight keeps the index and argument captured at its own acceptance.
- R9: done_o is high for exactly one cycle, the cycle right after the final stop bit. busy_o is low in that cycle.
- R10: Asserting rst_ni low in the middle of a message returns tx_o high and busy_o low at once, and a later request sends a complete, correct message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle send request |
| vec_idx_i | input | 6 | Vector index, captured on an accepted request |
| vec_arg_i | input | 16 | Vector argument, captured on an accepted request |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Message in flight |
| done_o | output | 1 | One-cycle pulse after the last stop bit |

## Verification
The bench builds three copies of the block, each with a different configuration:
- Odd parity with a 4-cycle bit (12/3).
- No parity with a 2-cycle bit from a truncating quotient (5/2).
- Even parity with a 1-cycle bit, where the bit counter reloads to zero on every cycle.

All 64 index values, walking-one and extreme arguments are sent through each copy. Every cycle of every message is compared against a frame computed in the bench. This covers the parity sense for both settings, the divider edge case of one cycle per bit, the boundaries between characters, requests made while busy, and a reset that cuts a message short.

// File: rtl/vtx_pkg.sv
package vtx_pkg;
  localparam int CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/vtx_baud.sv
module vtx_baud #(
  parameter int BIT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= RELOAD;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= RELOAD;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == '0);

  assert_count_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || tick_o) |=> (cnt_q == RELOAD));
endmodule

// File: rtl/vtx_frame.sv
module vtx_frame
  import vtx_pkg::*;
#(
  parameter bit PARITY_EN  = 1'b1,
  parameter bit PARITY_ODD = 1'b1,
  localparam int FRAME_W   = CHAR_W + 2 + (PARITY_EN ? 1 : 0)
) (
  input  char_t              data_i,
  output logic [FRAME_W-1:0] frame_o
);
  // bit 0 leaves first: start, data LSB first, [parity], stop
  generate
    if (PARITY_EN) begin : g_par
      logic par;
      assign par     = (^data_i) ^ PARITY_ODD;
      assign frame_o = {1'b1, par, data_i, 1'b0};
    end else begin : g_nopar
      assign frame_o = {1'b1, data_i, 1'b0};
    end
  endgenerate
endmodule

// File: rtl/vtx_shift.sv
module vtx_shift #(
  parameter int MSG_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic             tick_i,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int BW = $clog2(MSG_W + 1);
  localparam logic [BW-1:0] LAST = BW'(MSG_W - 1);

  logic [MSG_W-1:0] sreg_q;
  logic [BW-1:0]    left_q;
  logic             line_q, busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      left_q <= '0;
      line_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !busy_q) begin
        line_q <= msg_i[0];
        sreg_q <= msg_i >> 1;
        left_q <= LAST;
        busy_q <= 1'b1;
      end else if (busy_q && tick_i) begin
        if (left_q == '0) begin
          line_q <= 1'b1;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          line_q <= sreg_q[0];
          sreg_q <= sreg_q >> 1;
          left_q <= left_q - BW'(1);
        end
      end
    end
  end

  assign line_o = line_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> line_q);

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !line_q);

  assert_bit_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> $stable(line_q));

  assert_done_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/vec_cmd_tx.sv
module vec_cmd_tx
  import vtx_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BIT_HZ     = 115_200,
  parameter bit PARITY_EN  = 1'b0,
  parameter bit PARITY_ODD = 1'b0,
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IDX_W-1:0] vec_idx_i,
  input  logic [ARG_W-1:0] vec_arg_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int BIT_CYC = CLK_HZ / BIT_HZ;
  localparam int FRAME_W = CHAR_W + 2 + (PARITY_EN ? 1 : 0);
  localparam int CHARS   = 1 + ARG_W / CHAR_W;
  localparam int MSG_W   = CHARS * FRAME_W;

  logic             accept, tick, busy;
  logic [MSG_W-1:0] msg;
  char_t            chars [CHARS];

  assign accept = req_i && !busy;

  // char 0: index, then argument bytes low to high
  assign chars[0] = {{(CHAR_W - IDX_W){1'b0}}, vec_idx_i};

  generate
    for (genvar c = 1; c < CHARS; c++) begin : g_arg
      assign chars[c] = vec_arg_i[(c-1)*CHAR_W +: CHAR_W];
    end
    for (genvar c = 0; c < CHARS; c++) begin : g_frm
      vtx_frame #(
        .PARITY_EN (PARITY_EN),
        .PARITY_ODD(PARITY_ODD)
      ) u_frame (
        .data_i (chars[c]),
        .frame_o(msg[c*FRAME_W +: FRAME_W])
      );
    end
  endgenerate

  vtx_baud #(.BIT_CYC(BIT_CYC)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .run_i  (busy),
    .tick_o (tick)
  );

  vtx_shift #(.MSG_W(MSG_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .msg_i (msg),
    .tick_i(tick),
    .line_o(tx_o),
    .busy_o(busy),
    .done_o(done_o)
  );

  assign busy_o = busy;

  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && req_i && !tick) |=> (busy && $stable(tx_o)));

  assert_busy_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/sim_vec_cmd_tx.sv
`timescale 1ns/1ps
module sim_vec_cmd_tx;
  localparam int BC [3] = '{4, 2, 1};
  localparam bit PE [3] = '{1'b1, 1'b0, 1'b1};
  localparam bit PO [3] = '{1'b1, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  req = '0;
  logic [5:0]  idx = '0;
  logic [15:0] arg = '0;
  logic [2:0]  tx, busy, done;
  int          checks = 0, failures = 0;
  bit          ended = 1'b0;

  always #2.5 clk = ~clk;

  vec_cmd_tx #(.CLK_HZ(12), .BIT_HZ(3), .PARITY_EN(1'b1), .PARITY_ODD(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req[0]), .vec_idx_i(idx), .vec_arg_i(arg),
    .tx_o(tx[0]), .busy_o(busy[0]), .done_o(done[0]));
  vec_cmd_tx #(.CLK_HZ(5), .BIT_HZ(2), .PARITY_EN(1'b0), .PARITY_ODD(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req[1]), .vec_idx_i(idx), .vec_arg_i(arg),
    .tx_o(tx[1]), .busy_o(busy[1]), .done_o(done[1]));
  vec_cmd_tx #(.CLK_HZ(3), .BIT_HZ(3), .PARITY_EN(1'b1), .PARITY_ODD(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req[2]), .vec_idx_i(idx), .vec_arg_i(arg),
    .tx_o(tx[2]), .busy_o(busy[2]), .done_o(done[2]));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fw(int u);
    return 10 + (PE[u] ? 1 : 0);
  endfunction

  function automatic logic exp_bit(int u, logic [5:0] ix, logic [15:0] ag, int b);
    int c = b / fw(u);
    int p = b % fw(u);
    logic [7:0] by;
    by = (c == 0) ? {2'b00, ix} : (c == 1) ? ag[7:0] : ag[15:8];
    if (p == 0) return 1'b0;
    if (p <= 8) return by[p-1];
    if (PE[u] && p == 9) return (^by) ^ PO[u];
    return 1'b1;
  endfunction

  function automatic string tag_of(int u, int b, bit poke);
    int p = b % fw(u);
    if (poke) return "R8";
    if (b == 0) return "R2";
    if (p == 0) return (b < fw(u)) ? "R3" : "R7";
    if (p <= 8) return "R4";
    if (PE[u] && p == 9) return "R6";
    return "R3";
  endfunction

  task automatic send(input int u, input logic [5:0] ix, input logic [15:0] ag, input bit poke);
    int nb = 3 * fw(u);
    int len = nb * BC[u];
    @(negedge clk);
    idx = ix; arg = ag; req[u] = 1'b1;
    @(negedge clk);
    req[u] = 1'b0;
    for (int t = 0; t <= len; t++) begin
      req[u] = 1'b0;
      if (t < len) begin
        chk(tx[u] == exp_bit(u, ix, ag, t / BC[u]), tag_of(u, t / BC[u], poke),
            tx[u], exp_bit(u, ix, ag, t / BC[u]));
        chk(busy[u] && !done[u], "R5", {busy[u], done[u]}, 2);
      end else begin
        chk(done[u] && !busy[u], "R9", {busy[u], done[u]}, 1);
        chk(tx[u], "R1", tx[u], 1);
      end
      if (poke && t == 3) begin
        idx = ~ix; arg = ~ag; req[u] = 1'b1;
      end
      @(negedge clk);
    end
    chk(!done[u] && !busy[u] && tx[u], "R9", {tx[u], busy[u], done[u]}, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx == 3'b111 && busy == 3'b000 && done == 3'b000, "R1", {tx, busy, done}, 9'h1C0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx == 3'b111 && busy == 3'b000 && done == 3'b000, "R1", {tx, busy, done}, 9'h1C0);
    for (int u = 0; u < 3; u++) begin
      for (int i = 0; i < 64; i++)
        send(u, 6'(i), {6'(~i), 4'(i), 6'(i * 5)}, (i % 16) == 7);
      for (int k = 0; k < 16; k++)
        send(u, 6'(k), 16'(1) << k, 1'b0);
      send(u, 6'h3F, 16'hFFFF, 1'b1);
      send(u, 6'h00, 16'h0000, 1'b0);
      send(u, 6'h2A, 16'hA55A, 1'b0);
    end
    // R10: reset mid-message
    @(negedge clk);
    idx = 6'h15; arg = 16'h1234; req = 3'b111;
    @(negedge clk);
    req = '0;
    repeat (20) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(tx == 3'b111 && busy == 3'b000, "R10", {tx, busy}, 6'h38);
    @(negedge clk);
    chk(tx == 3'b111 && busy == 3'b000 && done == 3'b000, "R10", {tx, busy, done}, 9'h1C0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 3; u++) send(u, 6'h31, 16'hC3E1, 1'b0);
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule